// File: doc/BRIEF.md
# Crosstalk Transition Class Monitor

This block watches a parallel on-chip data bus without affecting it. On every transfer cycle in which the valid strobe is high, it compares the new bus word with the word seen before. Each wire is treated as a victim. Its two immediate neighbours act as aggressors, and wires further away play no part. A wire that switches gets a coupling weight k from 0 to 4. Each neighbour adds to k:

| Neighbour behaviour | Added to k |
|---|---|
| Moves the same way as the victim | 0 |
| Holds its value | 1 |
| Moves the opposite way | 2 |

The weight k selects one of five delay classes, g = 1 + k·r. The delay class does not depend on whether the victim rises or falls.

For energy the monitor uses a separate classification. Every rising victim lands in a single rising class, whatever its neighbours do. A falling victim lands in falling class j = k. Wires that do not switch are counted as quiet and belong to no delay class. Every wire also has its own toggle counter, and a word counter records how many words were classified.

Software reads the counters through an address and read-data pair and computes the ratios from them:
- per-wire activity is the toggle count divided by the word count;
- a class's share is its count divided by the total number of switching events.

A clear strobe zeroes every counter and forgets the previous word. The first valid word after reset or after a clear therefore only primes the comparison.

Top module: `xtalk_class_mon`

## Requirements
- R1: After reset every readable counter returns 0.
- R2: The first valid word after reset or after a clear is stored as the reference and is not classified: no counter changes.
- R3: The word counter (address 0) increases by one for each valid word that is compared against a stored reference.
- R4: For each switching wire, k is the sum of its two neighbour contributions: 0 for the same direction, 1 for stable, 2 for the opposite direction. The delay counter at address 2+k grows by one for each such wire, and the value is the same for rising and falling victims.
- R5: Bit 0 and bit BUS_W-1 treat their missing neighbour as stable, so it contributes 1.
- R6: Each wire whose value does not change in a classified word adds one to the quiet counter (address 1) and to no delay or energy class.
- R7: Each rising wire (0 to 1) adds one to the rising energy counter (address 7), whatever its neighbours do.
- R8: Each falling wire (1 to 0) adds one to the falling energy counter at address 8+k.
- R9: The toggle counter of wire i (address 13+i) grows by one for each classified word in which that wire changes.
- R10: Every counter saturates at its all-ones value and never wraps.
- R11: The clear strobe zeroes all counters and the reference-valid flag in the same cycle. A valid word that arrives in the clear cycle is discarded.
- R12: Cycles with the valid strobe low change no counter. Addresses beyond the last toggle counter read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A bus word is present this cycle |
| in_word | input | BUS_W | Bus word being sampled |
| clr | input | 1 | Clear strobe for all counters and the stored reference |
| rd_addr | input | ADDR_W | Counter select for read-out |
| rd_data | output | CNT_W | Selected counter value, combinational from rd_addr |

## Verification
Two functions can fall in the same cycle:
- **Clear and a new valid word.** The bench raises clr together with in_valid carrying a word that differs in every bit from the stored one. A correct design discards that word, reads all zeros afterwards, and treats the next word only as a reference. If the clear-cycle word were kept or classified, the word or rising counts would be off by one word.
- **Saturation and further increments.** Several counters are pushed well past the all-ones value of a narrow counter instance in the same word cycles. Each must then read exactly all ones. A wide instance fed the same stimulus must show the true, unsaturated count.

// File: rtl/xtm_pkg.sv
package xtm_pkg;

  localparam int NUM_K      = 5;
  localparam int IDX_WORDS  = 0;
  localparam int IDX_QUIET  = 1;
  localparam int IDX_DLY0   = 2;
  localparam int IDX_RISE   = IDX_DLY0 + NUM_K;
  localparam int IDX_FALL0  = IDX_RISE + 1;
  localparam int IDX_TGL0   = IDX_FALL0 + NUM_K;

  typedef logic [2:0] kw_t;

  typedef struct packed {
    logic tgl;
    logic rise;
    logic fall;
    kw_t  k;
  } wire_cls_t;

endpackage

// File: rtl/xtm_rst_sync.sv
module xtm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];

endmodule

// File: rtl/xtm_wire_class.sv
module xtm_wire_class
  import xtm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      prev_l,
  input  logic      cur_l,
  input  logic      prev_v,
  input  logic      cur_v,
  input  logic      prev_r,
  input  logic      cur_r,
  output wire_cls_t cls
);

  // Contribution of one neighbour to the victim's coupling weight.
  function automatic kw_t nb_weight(input logic np, input logic nc, input logic vc);
    kw_t w;
    if (np == nc)      w = 3'd1;
    else if (nc == vc) w = 3'd0;
    else               w = 3'd2;
    return w;
  endfunction

  logic v_tgl;
  kw_t  w_l;
  kw_t  w_r;

  always_comb begin
    v_tgl    = prev_v ^ cur_v;
    w_l      = nb_weight(prev_l, cur_l, cur_v);
    w_r      = nb_weight(prev_r, cur_r, cur_v);
    cls.tgl  = v_tgl;
    cls.rise = v_tgl & cur_v;
    cls.fall = v_tgl & ~cur_v;
    cls.k    = v_tgl ? (w_l + w_r) : 3'd0;
  end

  AST_QUIET_UNCLASSED: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_v == cur_v) |-> (cls.k == 3'd0 && !cls.rise && !cls.fall)); // R6

  AST_SAME_DIR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((prev_v != cur_v) && (prev_l != cur_l) && (prev_r != cur_r) &&
     (cur_l == cur_v) && (cur_r == cur_v)) |-> (cls.k == 3'd0)); // R4

endmodule

// File: rtl/xtm_tally.sv
module xtm_tally
  import xtm_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int INC_W = $clog2(BUS_W + 1)
) (
  input  wire_cls_t        cls [BUS_W],
  output logic [INC_W-1:0] n_quiet,
  output logic [INC_W-1:0] n_dly  [NUM_K],
  output logic [INC_W-1:0] n_rise,
  output logic [INC_W-1:0] n_fall [NUM_K]
);

  always_comb begin
    n_quiet = '0;
    n_rise  = '0;
    for (int j = 0; j < NUM_K; j++) begin
      n_dly[j]  = '0;
      n_fall[j] = '0;
    end
    for (int i = 0; i < BUS_W; i++) begin
      if (!cls[i].tgl) n_quiet = n_quiet + 1'b1;
      if (cls[i].rise) n_rise  = n_rise + 1'b1;
      for (int j = 0; j < NUM_K; j++) begin
        if (cls[i].tgl && cls[i].k == kw_t'(j))  n_dly[j]  = n_dly[j] + 1'b1;
        if (cls[i].fall && cls[i].k == kw_t'(j)) n_fall[j] = n_fall[j] + 1'b1;
      end
    end
  end

endmodule

// File: rtl/xtm_sat_cnt.sv
module xtm_sat_cnt #(
  parameter int CNT_W = 32,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    sum   = {1'b0, cnt} + (CNT_W+1)'(inc);
    cnt_d = cnt;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt == '1) |=> (cnt == '1)); // R10

  AST_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt >= $past(cnt))); // R10

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(cnt)); // R12

endmodule

// File: rtl/xtalk_class_mon.sv
module xtalk_class_mon
  import xtm_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = $clog2(IDX_TGL0 + BUS_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BUS_W-1:0]  in_word,
  input  logic              clr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data
);

  localparam int NUM_CNT = IDX_TGL0 + BUS_W;
  localparam int INC_W   = $clog2(BUS_W + 1);

  logic             rst_n_s;
  logic [BUS_W-1:0] ref_q;
  logic [BUS_W-1:0] ref_d;
  logic             ref_vld_q;
  logic             ref_vld_d;
  logic             classify;

  wire_cls_t        cls     [BUS_W];
  logic [INC_W-1:0] n_quiet;
  logic [INC_W-1:0] n_dly   [NUM_K];
  logic [INC_W-1:0] n_rise;
  logic [INC_W-1:0] n_fall  [NUM_K];
  logic [INC_W-1:0] inc_arr [NUM_CNT];
  logic [CNT_W-1:0] cnt_arr [NUM_CNT];

  xtm_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  // Reference word register: clear wins over a coincident word.
  always_comb begin
    ref_d     = ref_q;
    ref_vld_d = ref_vld_q;
    if (clr) begin
      ref_vld_d = 1'b0;
    end else if (in_valid) begin
      ref_d     = in_word;
      ref_vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ref_q     <= '0;
      ref_vld_q <= 1'b0;
    end else begin
      ref_q     <= ref_d;
      ref_vld_q <= ref_vld_d;
    end
  end

  assign classify = in_valid & ref_vld_q & ~clr;

  // One classifier per wire; edge wires see a stable virtual neighbour.
  for (genvar i = 0; i < BUS_W; i++) begin : g_wire
    logic pl, cl, pr, cr;
    if (i == 0) begin : g_lo_edge
      assign pl = 1'b0;
      assign cl = 1'b0;
    end else begin : g_lo_nb
      assign pl = ref_q[i-1];
      assign cl = in_word[i-1];
    end
    if (i == BUS_W - 1) begin : g_hi_edge
      assign pr = 1'b0;
      assign cr = 1'b0;
    end else begin : g_hi_nb
      assign pr = ref_q[i+1];
      assign cr = in_word[i+1];
    end
    xtm_wire_class u_cls (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .prev_l (pl),
      .cur_l  (cl),
      .prev_v (ref_q[i]),
      .cur_v  (in_word[i]),
      .prev_r (pr),
      .cur_r  (cr),
      .cls    (cls[i])
    );
  end

  xtm_tally #(.BUS_W(BUS_W), .INC_W(INC_W)) u_tally (
    .cls     (cls),
    .n_quiet (n_quiet),
    .n_dly   (n_dly),
    .n_rise  (n_rise),
    .n_fall  (n_fall)
  );

  always_comb begin
    inc_arr[IDX_WORDS] = INC_W'(1);
    inc_arr[IDX_QUIET] = n_quiet;
    inc_arr[IDX_RISE]  = n_rise;
    for (int j = 0; j < NUM_K; j++) begin
      inc_arr[IDX_DLY0 + j]  = n_dly[j];
      inc_arr[IDX_FALL0 + j] = n_fall[j];
    end
    for (int i = 0; i < BUS_W; i++) begin
      inc_arr[IDX_TGL0 + i] = INC_W'(cls[i].tgl);
    end
  end

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    xtm_sat_cnt #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n_s),
      .clr   (clr),
      .en    (classify),
      .inc   (inc_arr[c]),
      .cnt   (cnt_arr[c])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int a = 0; a < NUM_CNT; a++) begin
      if (rd_addr == ADDR_W'(a)) rd_data = cnt_arr[a];
    end
  end

  // Cross-checks between the tally outputs.
  logic [INC_W+2:0] sum_dly;
  logic [INC_W+2:0] sum_fall;

  always_comb begin
    sum_dly  = '0;
    sum_fall = '0;
    for (int j = 0; j < NUM_K; j++) begin
      sum_dly  = sum_dly + (INC_W+3)'(n_dly[j]);
      sum_fall = sum_fall + (INC_W+3)'(n_fall[j]);
    end
  end

  AST_ENERGY_MATCHES_DELAY: assert property (@(posedge clk) disable iff (!rst_n_s)
    classify |-> (sum_dly == sum_fall + (INC_W+3)'(n_rise))); // R8

  AST_EVERY_WIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n_s)
    classify |-> (sum_dly + (INC_W+3)'(n_quiet) == (INC_W+3)'(BUS_W))); // R6

  AST_FIRST_WORD_SILENT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_valid && !ref_vld_q && !clr) |=> $stable(cnt_arr[IDX_WORDS])); // R2

  AST_CLR_DROPS_REF: assert property (@(posedge clk) disable iff (!rst_n_s)
    clr |=> !ref_vld_q); // R11

endmodule

// File: tb/xtalk_class_mon_tb.sv
module xtalk_class_mon_tb;

  localparam int BUS_W  = 8;
  localparam int ADDR_W = 5;
  localparam int NV     = 11;

  // {prev, cur, quiet, d0..d4, rise, f0..f4}, one hex digit per count.
  localparam logic [63:0] VEC [NV] = '{
    64'h00FF_0620_0080_0000,
    64'hFF00_0620_0006_2000,
    64'h0055_4004_0040_0000,
    64'h55AA_0000_2640_0013,
    64'h0001_7001_0010_0000,
    64'h8000_7001_0000_0100,
    64'h1800_6020_0000_2000,
    64'h0006_6020_0020_0000,
    64'h0A05_4000_2220_0011,
    64'h040A_5000_2120_0001,
    64'h3C3C_8000_0000_0000
  };

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic [BUS_W-1:0]  in_word;
  logic              clr;
  logic [ADDR_W-1:0] rd_addr;
  logic [31:0]       rd_data;
  logic [5:0]        rd_data_sat;

  int n_chk;
  int n_bad;

  xtalk_class_mon #(.BUS_W(BUS_W), .CNT_W(32), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .clr(clr), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  xtalk_class_mon #(.BUS_W(BUS_W), .CNT_W(6), .ADDR_W(ADDR_W)) u_sat (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .clr(clr), .rd_addr(rd_addr), .rd_data(rd_data_sat)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] v, output logic [31:0] vs);
    rd_addr = ADDR_W'(a);
    #1;
    v  = rd_data;
    vs = {26'd0, rd_data_sat};
  endtask

  task automatic send(input logic [BUS_W-1:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, vs;
    logic [63:0] e;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; clr = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state of every counter
    for (int a = 0; a < 21; a++) begin
      rd(a, v, vs);
      chk($sformatf("R1 reset addr %0d", a), v, 0);
    end

    // R12: idle cycles with a moving bus word count nothing
    send(8'h00);
    @(negedge clk); in_word = 8'hFF;
    @(negedge clk); in_word = 8'h33;
    @(negedge clk);
    rd(0, v, vs); chk("R12 idle words", v, 0);
    rd(1, v, vs); chk("R12 idle quiet", v, 0);
    rd(7, v, vs); chk("R12 idle rise", v, 0);
    rd(22, v, vs); chk("R12 unmapped addr", v, 0);

    // Vector table: R3 R4 R5 R6 R7 R8
    for (int n = 0; n < NV; n++) begin
      e = VEC[n];
      do_clr();
      send(e[63:56]);
      rd(0, v, vs); chk($sformatf("R2 vec %0d first word", n), v, 0);
      send(e[55:48]);
      rd(0, v, vs); chk($sformatf("R3 vec %0d words", n), v, 1);
      rd(1, v, vs); chk($sformatf("R6 vec %0d quiet", n), v, {28'd0, e[47:44]});
      for (int k = 0; k < 5; k++) begin
        rd(2 + k, v, vs);
        chk($sformatf("R4 R5 vec %0d delay k%0d", n, k), v, {28'd0, e[43-4*k -: 4]});
        rd(8 + k, v, vs);
        chk($sformatf("R8 R5 vec %0d fall j%0d", n, k), v, {28'd0, e[19-4*k -: 4]});
      end
      rd(7, v, vs); chk($sformatf("R7 vec %0d rise", n), v, {28'd0, e[23:20]});
    end

    // R9: per-wire toggle counters
    do_clr();
    send(8'h00); send(8'h03); send(8'h01); send(8'h01);
    rd(0, v, vs);  chk("R3 toggle run words", v, 3);
    rd(13, v, vs); chk("R9 toggles bit0", v, 1);
    rd(14, v, vs); chk("R9 toggles bit1", v, 2);
    rd(15, v, vs); chk("R9 toggles bit2", v, 0);
    rd(20, v, vs); chk("R9 toggles bit7", v, 0);

    // R11: clear coinciding with a valid word
    do_clr();
    send(8'h00);
    @(negedge clk);
    in_valid = 1'b1; in_word = 8'hFF; clr = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; clr = 1'b0;
    rd(0, v, vs); chk("R11 words after clr", v, 0);
    rd(1, v, vs); chk("R11 quiet after clr", v, 0);
    send(8'h00);
    rd(0, v, vs); chk("R11 next word only primes", v, 0);
    rd(7, v, vs); chk("R11 rise after prime", v, 0);
    send(8'hFF);
    rd(0, v, vs); chk("R11 words after reload", v, 1);
    rd(7, v, vs); chk("R11 rise after reload", v, 8);

    // R10: saturation on the narrow instance
    do_clr();
    for (int n = 0; n < 71; n++) send((n % 2) ? 8'hFF : 8'h00);
    rd(0, v, vs);
    chk("R10 sat words", vs, 63);
    chk("R3 wide words", v, 70);
    rd(7, v, vs);  chk("R10 sat rise", vs, 63);
    chk("R7 wide rise", v, 280);
    rd(8, v, vs);  chk("R10 sat fall j0", vs, 63);
    rd(13, v, vs); chk("R10 sat toggles bit0", vs, 63);
    rd(1, v, vs);  chk("R10 sat quiet stays", vs, 0);
    send(8'h00);
    rd(0, v, vs);  chk("R10 sat words held", vs, 63);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule